// File: doc/BRIEF.md
# Two-Bank Piecewise-Linear Colour Table

This block stores a per-channel colour transfer table as a list of points, each holding a base value and a slope delta for red, green and blue. There are two complete copies of the table, bank A and bank B. The pixel path reads only the bank that is currently live. A host rewrites the other bank through a small register port, then makes it live with a single mode write. A read-only status field shows which bank the pixel path is using. In bypass the pixel code passes through unchanged.

Loading is sequential. The host selects a target bank, a channel mask and a word format, writes the start index, and then streams words into a data port. An internal phase counter walks the fixed per-point word order, and the index steps forward on its own after the last word of each point. The pixel side takes a 14-bit code per channel and uses its top bits as the table index. It returns base and delta one cycle later. Segment placement and interpolation belong to later stages.

Top module: `lut_dual_bank`

## Requirements
- R1: Register 0 holds the mode: writing 0 selects bypass, 1 makes bank A live, 2 makes bank B live, and any other value is stored as bypass. Reading register 0 returns the live state in bits [1:0] with that encoding, so it reads 0 after reset and never reads 3.
- R2: In bypass, a valid pixel returns its own per-channel code as the base and zero as the delta.
- R3: Register 1 bit 3 picks the load target: 0 writes bank A and 1 writes bank B. The bank that is not targeted is left unchanged.
- R4: Writing register 2 sets the load index from its low bits and restarts the per-point phase, so the next data word is the first word of that point.
- R5: With register 1 bit 4 clear (six-word format), each point is loaded by six writes to register 3 in this order: red base, green base, blue base, red delta, green delta, blue delta. Each word carries its value in its low bits.
- R6: With register 1 bit 4 set (three-word format), each point takes three writes (red, green, blue). Each word holds the delta in bits [23:14] and the base in bits [13:0]. Bits above 23 are ignored.
- R7: Register 1 bits [2:0] are a channel write mask (bit 0 red, bit 1 green, bit 2 blue). A word for a masked-off channel leaves the table unchanged but still advances the phase.
- R8: After the last word of a point the load index steps by one and wraps from the last point to 0. Register 2 reads back the current load index.
- R9: The live bank changes only on a write to register 0. Loading the other bank leaves the pixel results unchanged.
- R10: Register 4 bit 0 forces the table memory off and is 1 after reset. While it is 1, data-port writes are dropped without advancing the phase or the index, and lookups in bank modes return zero base and delta.
- R11: A pixel presented with its valid flag produces a result with the valid flag exactly one cycle later. Each channel's table index is the top 4 bits of its 14-bit code, and the result is that point's base and delta from the live bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Register write strobe |
| hostAddr | input | 3 | Register address |
| hostWrData | input | 32 | Register write data |
| hostRdData | output | 32 | Register read data (combinational) |
| pixInValid | input | 1 | Pixel input valid |
| pixInCode | input | 42 | Pixel codes, red in [13:0], green in [27:14], blue in [41:28] |
| pixOutValid | output | 1 | Result valid |
| pixOutBase | output | 42 | Base per channel, same packing as pixInCode |
| pixOutDelta | output | 30 | Delta per channel, red in [9:0], green in [19:10], blue in [29:20] |

## Verification
A phase counter that falls out of step with the word stream puts a value in the wrong channel or field. That error appears at the next lookup of the affected point and at the index readback after that point. A wrong live-bank register or a write that strays into the live bank changes the pixel results on the very next cycle. This is why lookups are interleaved with the loading of the other bank. Index drift caused by writes that should have been dropped shows up at once in the register 2 readback.

// File: rtl/lut_pkg.sv
package lut_pkg;

  localparam int NUM_CH     = 3;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_MODE  = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_LDCFG = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_INDEX = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_DATA  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_POWER = 3'd4;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_RAM_A  = 2'd1,
    MODE_RAM_B  = 2'd2
  } lutMode_e;

  typedef struct packed {
    logic       memWr;
    logic       wrBank;
    logic [1:0] wrChan;
    logic       wrBase;
    logic       wrDelta;
  } lutWrStrobe_t;

endpackage

// File: rtl/lut_ctrl.sv
module lut_ctrl
  import lut_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_POINTS = 16,
  parameter int IDX_W      = 4,
  parameter int BASE_W     = 14,
  parameter int DELTA_W    = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostWrEn,
  input  logic [REG_ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]     hostWrData,
  output logic [DATA_W-1:0]     hostRdData,
  output lutMode_e              activeMode,
  output logic                  pwrOff,
  output lutWrStrobe_t          wrStrobe,
  output logic [IDX_W-1:0]      wrIdx,
  output logic [BASE_W-1:0]     wrBaseVal,
  output logic [DELTA_W-1:0]    wrDeltaVal
);

  localparam int PH_W          = 3;
  localparam int LAST_UNPACKED = 2 * NUM_CH - 1;
  localparam int LAST_PACKED   = NUM_CH - 1;

  lutMode_e         modeQ;
  logic [2:0]       maskQ;
  logic             selQ;
  logic             packedQ;
  logic [IDX_W-1:0] idxQ;
  logic [PH_W-1:0]  phaseQ;
  logic             pwrOffQ;

  logic            dataWr;
  logic [PH_W-1:0] lastPhase;
  logic [PH_W-1:0] chanFull;
  logic            unusedBits;

  assign unusedBits = ^hostWrData[DATA_W-1:BASE_W+DELTA_W];

  assign dataWr    = hostWrEn && (hostAddr == ADDR_DATA) && !pwrOffQ;
  assign lastPhase = packedQ ? PH_W'(LAST_PACKED) : PH_W'(LAST_UNPACKED);

  always_comb begin
    if (packedQ || phaseQ < PH_W'(NUM_CH)) chanFull = phaseQ;
    else                                    chanFull = phaseQ - PH_W'(NUM_CH);
  end

  always_comb begin
    wrStrobe.wrChan  = chanFull[1:0];
    wrStrobe.wrBank  = selQ;
    wrStrobe.wrBase  = packedQ || (phaseQ < PH_W'(NUM_CH));
    wrStrobe.wrDelta = packedQ || (phaseQ >= PH_W'(NUM_CH));
    wrStrobe.memWr   = dataWr && maskQ[chanFull[1:0]];
  end

  assign wrIdx      = idxQ;
  assign wrBaseVal  = hostWrData[BASE_W-1:0];
  assign wrDeltaVal = packedQ ? hostWrData[BASE_W +: DELTA_W] : hostWrData[DELTA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_BYPASS;
      maskQ   <= '0;
      selQ    <= 1'b0;
      packedQ <= 1'b0;
      idxQ    <= '0;
      phaseQ  <= '0;
      pwrOffQ <= 1'b1;
    end else if (hostWrEn) begin
      unique case (hostAddr)
        ADDR_MODE: begin
          case (hostWrData[1:0])
            2'd1:    modeQ <= MODE_RAM_A;
            2'd2:    modeQ <= MODE_RAM_B;
            default: modeQ <= MODE_BYPASS;
          endcase
        end
        ADDR_LDCFG: begin
          maskQ   <= hostWrData[2:0];
          selQ    <= hostWrData[3];
          packedQ <= hostWrData[4];
        end
        ADDR_INDEX: begin
          idxQ   <= hostWrData[IDX_W-1:0];
          phaseQ <= '0;
        end
        ADDR_DATA: begin
          if (dataWr) begin
            if (phaseQ == lastPhase) begin
              phaseQ <= '0;
              idxQ   <= (idxQ == IDX_W'(NUM_POINTS - 1)) ? '0 : idxQ + 1'b1;
            end else begin
              phaseQ <= phaseQ + 1'b1;
            end
          end
        end
        ADDR_POWER: pwrOffQ <= hostWrData[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    hostRdData = '0;
    case (hostAddr)
      ADDR_MODE:  hostRdData[1:0]       = modeQ;
      ADDR_LDCFG: hostRdData[4:0]       = {packedQ, selQ, maskQ};
      ADDR_INDEX: hostRdData[IDX_W-1:0] = idxQ;
      ADDR_POWER: hostRdData[0]         = pwrOffQ;
      default:    hostRdData            = '0;
    endcase
  end

  assign activeMode = modeQ;
  assign pwrOff     = pwrOffQ;

  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    modeQ != 2'd3);

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && hostAddr == ADDR_MODE) |=> $stable(modeQ));

  p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ <= PH_W'(LAST_UNPACKED));

  p_index_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && phaseQ == lastPhase && idxQ != IDX_W'(NUM_POINTS - 1))
      |=> idxQ == $past(idxQ) + 1'b1);

  p_off_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pwrOffQ && hostWrEn && hostAddr == ADDR_DATA) |=> ($stable(idxQ) && $stable(phaseQ)));

endmodule

// File: rtl/lut_datapath.sv
module lut_datapath
  import lut_pkg::*;
#(
  parameter int NUM_POINTS = 16,
  parameter int IDX_W      = 4,
  parameter int BASE_W     = 14,
  parameter int DELTA_W    = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  lutWrStrobe_t              wrStrobe,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic [BASE_W-1:0]         wrBaseVal,
  input  logic [DELTA_W-1:0]        wrDeltaVal,
  input  lutMode_e                  activeMode,
  input  logic                      pwrOff,
  input  logic                      pixInValid,
  input  logic [NUM_CH*BASE_W-1:0]  pixInCode,
  output logic                      pixOutValid,
  output logic [NUM_CH*BASE_W-1:0]  pixOutBase,
  output logic [NUM_CH*DELTA_W-1:0] pixOutDelta
);

  localparam int NUM_BANKS = 2;

  logic readBank;
  assign readBank = (activeMode == MODE_RAM_B);

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [BASE_W-1:0]  baseMem  [NUM_BANKS][NUM_POINTS];
    logic [DELTA_W-1:0] deltaMem [NUM_BANKS][NUM_POINTS];
    logic               wrHit;
    logic [IDX_W-1:0]   readIdx;
    logic [BASE_W-1:0]  codeCh;
    logic [BASE_W-1:0]  nxtBase;
    logic [DELTA_W-1:0] nxtDelta;
    logic [BASE_W-1:0]  outBaseQ;
    logic [DELTA_W-1:0] outDeltaQ;

    assign wrHit   = wrStrobe.memWr && (wrStrobe.wrChan == 2'(c));
    assign codeCh  = pixInCode[c*BASE_W +: BASE_W];
    assign readIdx = codeCh[BASE_W-1 -: IDX_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          for (int i = 0; i < NUM_POINTS; i++) begin
            baseMem[b][i]  <= '0;
            deltaMem[b][i] <= '0;
          end
        end
      end else if (wrHit) begin
        if (wrStrobe.wrBase)  baseMem[wrStrobe.wrBank][wrIdx]  <= wrBaseVal;
        if (wrStrobe.wrDelta) deltaMem[wrStrobe.wrBank][wrIdx] <= wrDeltaVal;
      end
    end

    always_comb begin
      if (activeMode == MODE_BYPASS) begin
        nxtBase  = codeCh;
        nxtDelta = '0;
      end else if (pwrOff) begin
        nxtBase  = '0;
        nxtDelta = '0;
      end else begin
        nxtBase  = baseMem[readBank][readIdx];
        nxtDelta = deltaMem[readBank][readIdx];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outBaseQ  <= '0;
        outDeltaQ <= '0;
      end else if (pixInValid) begin
        outBaseQ  <= nxtBase;
        outDeltaQ <= nxtDelta;
      end
    end

    assign pixOutBase[c*BASE_W +: BASE_W]    = outBaseQ;
    assign pixOutDelta[c*DELTA_W +: DELTA_W] = outDeltaQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixOutValid <= 1'b0;
    else       pixOutValid <= pixInValid;
  end

  p_off_nowrite_r10: assert property (@(posedge clk) disable iff (!rstN)
    pwrOff |-> !wrStrobe.memWr);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rstN)
    pixInValid |=> pixOutValid);

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rstN)
    !pixInValid |=> !pixOutValid);

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pixInValid && activeMode == MODE_BYPASS) |=> (pixOutBase == $past(pixInCode) && pixOutDelta == '0));

endmodule

// File: rtl/lut_dual_bank.sv
module lut_dual_bank
  import lut_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_POINTS = 16,
  parameter int IDX_W      = $clog2(NUM_POINTS),
  parameter int BASE_W     = 14,
  parameter int DELTA_W    = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hostWrEn,
  input  logic [REG_ADDR_W-1:0]     hostAddr,
  input  logic [DATA_W-1:0]         hostWrData,
  output logic [DATA_W-1:0]         hostRdData,
  input  logic                      pixInValid,
  input  logic [NUM_CH*BASE_W-1:0]  pixInCode,
  output logic                      pixOutValid,
  output logic [NUM_CH*BASE_W-1:0]  pixOutBase,
  output logic [NUM_CH*DELTA_W-1:0] pixOutDelta
);

  lutMode_e           activeMode;
  logic               pwrOff;
  lutWrStrobe_t       wrStrobe;
  logic [IDX_W-1:0]   wrIdx;
  logic [BASE_W-1:0]  wrBaseVal;
  logic [DELTA_W-1:0] wrDeltaVal;

  lut_ctrl #(
    .DATA_W(DATA_W), .NUM_POINTS(NUM_POINTS), .IDX_W(IDX_W),
    .BASE_W(BASE_W), .DELTA_W(DELTA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData),
    .activeMode(activeMode), .pwrOff(pwrOff), .wrStrobe(wrStrobe),
    .wrIdx(wrIdx), .wrBaseVal(wrBaseVal), .wrDeltaVal(wrDeltaVal)
  );

  lut_datapath #(
    .NUM_POINTS(NUM_POINTS), .IDX_W(IDX_W),
    .BASE_W(BASE_W), .DELTA_W(DELTA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN),
    .wrStrobe(wrStrobe), .wrIdx(wrIdx), .wrBaseVal(wrBaseVal), .wrDeltaVal(wrDeltaVal),
    .activeMode(activeMode), .pwrOff(pwrOff),
    .pixInValid(pixInValid), .pixInCode(pixInCode),
    .pixOutValid(pixOutValid), .pixOutBase(pixOutBase), .pixOutDelta(pixOutDelta)
  );

endmodule

// File: tb/lut_dual_bank_tb.sv
`timescale 1ns/1ps
module lut_dual_bank_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        pixInValid = 1'b0;
  logic [41:0] pixInCode = '0;
  logic        pixOutValid;
  logic [41:0] pixOutBase;
  logic [29:0] pixOutDelta;

  always #2 clk = ~clk;

  lut_dual_bank dut_i (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .pixInValid(pixInValid), .pixInCode(pixInCode),
    .pixOutValid(pixOutValid), .pixOutBase(pixOutBase), .pixOutDelta(pixOutDelta)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int mBase  [2][3][16];
  int mDelta [2][3][16];
  int mMode = 0, mMask = 0, mSel = 0, mPacked = 0, mIdx = 0, mPhase = 0, mPwrOff = 1;

  logic [71:0] expQ [$];
  string       tagQ [$];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
    case (a)
      3'd0: mMode = (d[1:0] == 2'd1) ? 1 : (d[1:0] == 2'd2) ? 2 : 0;
      3'd1: begin mMask = int'(d[2:0]); mSel = int'(d[3]); mPacked = int'(d[4]); end
      3'd2: begin mIdx = int'(d[3:0]); mPhase = 0; end
      3'd4: mPwrOff = int'(d[0]);
      3'd3: if (mPwrOff == 0) begin
        int ch, last;
        last = mPacked ? 2 : 5;
        ch = mPacked ? mPhase : mPhase % 3;
        if (mMask[ch]) begin
          if (mPacked) begin
            mBase[mSel][ch][mIdx]  = int'(d[13:0]);
            mDelta[mSel][ch][mIdx] = int'(d[23:14]);
          end else if (mPhase < 3) mBase[mSel][ch][mIdx]  = int'(d[13:0]);
          else                     mDelta[mSel][ch][mIdx] = int'(d[9:0]);
        end
        if (mPhase == last) begin mPhase = 0; mIdx = (mIdx + 1) % 16; end
        else mPhase++;
      end
      default: ;
    endcase
  endtask

  task automatic hread(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdData;
  endtask

  task automatic lookup(string tag, logic [13:0] r, logic [13:0] g, logic [13:0] b);
    logic [41:0] eb;
    logic [29:0] ed;
    logic [13:0] cd [3];
    cd[0] = r; cd[1] = g; cd[2] = b;
    for (int c = 0; c < 3; c++) begin
      int ix;
      ix = int'(cd[c][13:10]);
      if (mMode == 0) begin
        eb[c*14 +: 14] = cd[c]; ed[c*10 +: 10] = '0;
      end else if (mPwrOff != 0) begin
        eb[c*14 +: 14] = '0; ed[c*10 +: 10] = '0;
      end else begin
        eb[c*14 +: 14] = 14'(mBase[mMode-1][c][ix]);
        ed[c*10 +: 10] = 10'(mDelta[mMode-1][c][ix]);
      end
    end
    @(negedge clk);
    pixInValid = 1'b1; pixInCode = {b, g, r};
    expQ.push_back({eb, ed});
    tagQ.push_back(tag);
    @(negedge clk);
    pixInValid = 1'b0;
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rstN && pixOutValid) begin
      if (expQ.size() == 0) chk("R11 unexpected result", 64'd1, 64'd0);
      else begin
        logic [71:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " base"},  64'(pixOutBase),  64'(e[71:30]));
        chk({t, " delta"}, 64'(pixOutDelta), 64'(e[29:0]));
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [13:0] codeOf(int ix, int low);
    return 14'((ix << 10) | (low & 10'h3ff));
  endfunction

  initial begin
    logic [31:0] rd;
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 3; c++)
        for (int i = 0; i < 16; i++) begin mBase[b][c][i] = 0; mDelta[b][c][i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    hread(3'd0, rd); chk("R1 reset status", 64'(rd), 64'd0);
    hread(3'd4, rd); chk("R10 reset power force", 64'(rd), 64'd1);
    chk("R11 reset valid", 64'(pixOutValid), 64'd0);

    // bypass with several codes
    lookup("R2 bypass", 14'h0000, 14'h3fff, 14'h1234);
    lookup("R2 bypass", 14'h2aaa, 14'h1555, 14'h0001);

    // power forced off
    hwrite(3'd0, 32'd1);
    lookup("R10 off lookup", codeOf(3, 5), codeOf(7, 1), codeOf(12, 0));
    hwrite(3'd1, 32'h07);
    hwrite(3'd2, 32'd4);
    hwrite(3'd3, 32'h1111);
    hwrite(3'd3, 32'h2222);
    hread(3'd2, rd); chk("R10 dropped writes index", 64'(rd), 64'd4);
    hwrite(3'd2, 32'd0);
    hwrite(3'd3, 32'h0aaa);
    lookup("R10 dropped write value", codeOf(0, 0), codeOf(0, 0), codeOf(0, 0));

    // power on, load bank A, six-word format
    hwrite(3'd4, 32'd0);
    hwrite(3'd1, 32'h07);
    hwrite(3'd2, 32'd0);
    for (int i = 0; i < 16; i++) begin
      hwrite(3'd3, 32'(100 + i * 7));
      hwrite(3'd3, 32'(2000 + i * 3));
      hwrite(3'd3, 32'(9000 + i));
      hwrite(3'd3, 32'(i + 1));
      hwrite(3'd3, 32'(2 * i + 5));
      hwrite(3'd3, 32'(1000 - i));
    end
    hread(3'd2, rd); chk("R8 index wrap", 64'(rd), 64'd0);
    lookup("R5 six-word point 0", codeOf(0, 9), codeOf(0, 3), codeOf(0, 1023));
    lookup("R5 R11 mixed points", codeOf(15, 0), codeOf(6, 77), codeOf(9, 500));
    lookup("R11 index from top bits", codeOf(11, 1023), codeOf(2, 0), codeOf(14, 1));

    // load bank B in three-word format while A is live
    hwrite(3'd1, 32'h1f);
    hwrite(3'd2, 32'd0);
    for (int i = 0; i < 16; i++) begin
      for (int c = 0; c < 3; c++) begin
        int bv, dv;
        bv = (c * 3000 + i * 37 + 5) & 16'h3fff;
        dv = (c * 200 + i * 9 + 1) & 10'h3ff;
        hwrite(3'd3, 32'hA5000000 | 32'(dv << 14) | 32'(bv));
      end
      lookup("R9 live bank A undisturbed", codeOf(i, 0), codeOf((i + 5) % 16, 0), codeOf(15 - i, 0));
    end
    hread(3'd0, rd); chk("R9 status stays A", 64'(rd), 64'd1);
    hwrite(3'd0, 32'd2);
    hread(3'd0, rd); chk("R1 status B", 64'(rd), 64'd2);
    lookup("R6 R3 packed bank B", codeOf(0, 0), codeOf(8, 12), codeOf(15, 3));
    lookup("R6 R3 packed bank B", codeOf(4, 0), codeOf(13, 0), codeOf(1, 0));

    // mask: green only, bank A, point 5
    hwrite(3'd1, 32'h02);
    hwrite(3'd2, 32'd5);
    hwrite(3'd3, 32'd111); hwrite(3'd3, 32'd222); hwrite(3'd3, 32'd333);
    hwrite(3'd3, 32'd11);  hwrite(3'd3, 32'd22);  hwrite(3'd3, 32'd33);
    hread(3'd2, rd); chk("R7 R8 masked words advance", 64'(rd), 64'd6);
    hwrite(3'd0, 32'd1);
    hread(3'd0, rd); chk("R1 status A", 64'(rd), 64'd1);
    lookup("R7 green only written", codeOf(5, 0), codeOf(5, 0), codeOf(5, 0));

    // index rewrite mid-point restarts phase (three-word, bank A)
    hwrite(3'd1, 32'h17);
    hwrite(3'd2, 32'd3);
    hwrite(3'd3, 32'h3fff);
    hwrite(3'd3, 32'h3ffe);
    hwrite(3'd2, 32'd3);
    hwrite(3'd3, (32'd17 << 14) | 32'd1700);
    hwrite(3'd3, (32'd18 << 14) | 32'd1800);
    hwrite(3'd3, (32'd19 << 14) | 32'd1900);
    hread(3'd2, rd); chk("R4 index after restart", 64'(rd), 64'd4);
    lookup("R4 phase restarted", codeOf(3, 0), codeOf(3, 0), codeOf(3, 0));
    hwrite(3'd0, 32'd2);
    lookup("R3 bank B untouched by A loads", codeOf(3, 0), codeOf(5, 0), codeOf(3, 0));

    // illegal mode value
    hwrite(3'd0, 32'd3);
    hread(3'd0, rd); chk("R1 value 3 reads bypass", 64'(rd), 64'd0);
    lookup("R1 R2 value 3 bypasses", 14'h0abc, 14'h3000, 14'h0007);

    repeat (4) @(negedge clk);
    chk("R11 all results seen", 64'(expQ.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule